// File: doc/BRIEF.md
# Serial Core Run-State and FIFO Service Controller

This block is the control unit that sits beside a serial protocol engine and gives software a small register window onto it. It keeps the engine's run state (held in reset, running, or paused), reports when a requested state change has settled, and lets software force the engine back into reset at any time. The protocol engine and the FIFOs themselves live elsewhere. Their occupancy indications arrive as plain inputs, and the engine reads the run state from dedicated outputs.

From the FIFO occupancy inputs the block derives an operational status word. It also raises two sticky service flags. One is raised when the outgoing FIFO drains and the other when incoming data first appears. Software clears each by writing 1 to it. A separate error-flag register captures error events from the engine. A companion enable register selects which captured errors drive an interrupt line.

Register map (word address on `regAddr`): 0 run state, 1 software reset, 2 operational status, 3 error flags, 4 error enables. Writes are single-cycle strobes on `regWe`. Reads are combinational from `regAddr`.

Top module: `serialCoreCtrl`

## Requirements
- R1: After reset the state register (address 0) reads 0x4. Bits 1:0 hold the run state, encoded RESET = 0, RUN = 1 and PAUSE = 3, and bit 2 is the settled flag. The encoding 2 never appears in bits 1:0.
- R2: An accepted state write puts the new code in bits 1:0 at the next clock edge. The settled flag then reads 0 for exactly SETTLE (default 4) cycles and returns to 1.
- R3: A state write made while the settled flag is 0 has no effect on the state register.
- R4: The code 2 is honoured only in PAUSE. The first write of 2 there changes nothing visible. A second write of 2 that is the very next register write moves the core to RESET. Any other register write in between cancels the pending first write. In any other state the code 2 is ignored, and a write of 0 while in PAUSE is also ignored.
- R5: Writing 1 to bit 0 of address 1 forces RESET with the settled flag low for SETTLE cycles. This happens whether or not the flag was set.
- R6: Operational register (address 2) bit 4 mirrors output-FIFO-not-empty, bit 5 mirrors input-FIFO-not-empty and bit 6 mirrors output-FIFO-full. All three read 0 while in RESET. `fifoFlush` pulses high for one cycle on every transition into RESET.
- R7: Operational bit 8 (output service) sets when output-FIFO-not-empty goes from 1 to 0 outside RESET. Writing 1 to bit 8 clears it, and it stays clear while the input stays low.
- R8: Operational bit 9 (input service) sets when input-FIFO-not-empty goes from 0 to 1 outside RESET. Writing 1 to bit 9 clears it.
- R9: Being in RESET clears both service flags.
- R10: Address 3 captures `errEvent` bits under mask 0x7C, and a write of 1 clears a bit. Address 4 is writable under the same mask. Bits outside the mask read 0. `errIrq` is high while any flag is set together with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for regAddr |
| outFifoNotEmpty | input | 1 | Outgoing FIFO holds data |
| inFifoNotEmpty | input | 1 | Incoming FIFO holds data |
| outFifoFull | input | 1 | Outgoing FIFO is full |
| errEvent | input | 7 | Error event pulses from the engine |
| coreState | output | 2 | Current run state code |
| coreValid | output | 1 | Run state has settled |
| fifoFlush | output | 1 | One-cycle pulse on entry into RESET |
| errIrq | output | 1 | Enabled error pending |

## Verification
The hardest situation to reach is the two-write exit from PAUSE. The core must first be settled in PAUSE, which takes a state write followed by a wait of SETTLE idle cycles. The two writes of 2 must then arrive as consecutive register writes, with no other write between them. The stimulus table walks that path in order. It also places a write to another address between two writes of 2, to show that the pending first write is dropped. Writes made during the settle window are placed on the cycles immediately after an accepted write, so they land while the flag is still low.

// File: rtl/sccPkg.sv
package sccPkg;

  localparam int ERR_W = 7;
  localparam logic [ERR_W-1:0] ERR_MASK = 7'h7C;

  localparam int ADDR_STATE  = 0;
  localparam int ADDR_SWRST  = 1;
  localparam int ADDR_OPER   = 2;
  localparam int ADDR_ERRFLG = 3;
  localparam int ADDR_ERREN  = 4;

  localparam int OPB_OUT_NE   = 4;
  localparam int OPB_IN_NE    = 5;
  localparam int OPB_OUT_FULL = 6;
  localparam int OPB_OUT_SVC  = 8;
  localparam int OPB_IN_SVC   = 9;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd3
  } coreState_e;

  typedef struct packed {
    logic inReset;
    logic opWrite;
    logic errClrWrite;
    logic errEnWrite;
  } ctrlStrobe_t;

endpackage

// File: rtl/sccControl.sv
module sccControl
  import sccPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        wrCode,
  output coreState_e        curState,
  output logic              coreValid,
  output logic              fifoFlush,
  output ctrlStrobe_t       strobe
);

  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam int RUN_W = CNT_W + 1;

  logic [CNT_W-1:0] settleCnt, nCnt;
  logic             pauseArmed, nArm;
  coreState_e       nState;
  logic             nValid, nFlush, startSettle;
  logic             wrState, wrSwRst;

  always_comb begin
    wrState = regWe && (regAddr == ADDR_W'(ADDR_STATE));
    wrSwRst = regWe && (regAddr == ADDR_W'(ADDR_SWRST)) && wrCode[0];
    strobe.inReset     = (curState == ST_RESET);
    strobe.opWrite     = regWe && (regAddr == ADDR_W'(ADDR_OPER));
    strobe.errClrWrite = regWe && (regAddr == ADDR_W'(ADDR_ERRFLG));
    strobe.errEnWrite  = regWe && (regAddr == ADDR_W'(ADDR_ERREN));
  end

  always_comb begin
    nState      = curState;
    nValid      = coreValid;
    nCnt        = settleCnt;
    nArm        = pauseArmed;
    nFlush      = 1'b0;
    startSettle = 1'b0;
    if (settleCnt != '0) begin
      nCnt = settleCnt - 1'b1;
      if (settleCnt == CNT_W'(1)) nValid = 1'b1;
    end
    if (wrSwRst) begin
      nState      = ST_RESET;
      nArm        = 1'b0;
      startSettle = 1'b1;
    end else if (regWe) begin
      nArm = 1'b0;
      if (wrState && coreValid) begin
        if (wrCode == 2'd2) begin
          if (curState == ST_PAUSE) begin
            if (pauseArmed) begin
              nState      = ST_RESET;
              startSettle = 1'b1;
            end else begin
              nArm = 1'b1;
            end
          end
        end else if (!(curState == ST_PAUSE && wrCode == 2'd0)) begin
          nState      = coreState_e'(wrCode);
          startSettle = 1'b1;
        end
      end
    end
    if (startSettle) begin
      nValid = 1'b0;
      nCnt   = CNT_W'(SETTLE);
      nFlush = (nState == ST_RESET);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_RESET;
      coreValid  <= 1'b1;
      settleCnt  <= '0;
      pauseArmed <= 1'b0;
      fifoFlush  <= 1'b0;
    end else begin
      curState   <= nState;
      coreValid  <= nValid;
      settleCnt  <= nCnt;
      pauseArmed <= nArm;
      fifoFlush  <= nFlush;
    end
  end

  // Watcher: length of the current low run of the settled flag
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (wrSwRst || coreValid) lowRun <= '0;
    else if (lowRun != '1) lowRun <= lowRun + 1'b1;
  end

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    curState != 2'd2);

  assert_settle_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (coreValid && !$past(coreValid)) |-> (lowRun == RUN_W'(SETTLE)));

  assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrState && !coreValid) |=> $stable(curState));

  assert_pause_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrState && coreValid && curState == ST_PAUSE && wrCode == 2'd2 && !pauseArmed)
      |=> (curState == ST_PAUSE));

  assert_swreset_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrSwRst |=> (curState == ST_RESET && !coreValid));

endmodule

// File: rtl/sccDatapath.sv
module sccDatapath
  import sccPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  coreState_e        curState,
  input  logic              coreValid,
  input  logic              outFifoNotEmpty,
  input  logic              inFifoNotEmpty,
  input  logic              outFifoFull,
  input  logic [ERR_W-1:0]  errEvent,
  output logic [DATA_W-1:0] regRdata,
  output logic              errIrq
);

  logic             maskOut, maskIn, maskFull;
  logic             prevOut, prevIn;
  logic             outSvc, inSvc;
  logic [ERR_W-1:0] errFlags, errEn, errClr;
  logic             unusedWdata;

  assign unusedWdata = ^{regWdata[DATA_W-1:OPB_IN_SVC+1], regWdata[ERR_W]};

  always_comb begin
    maskOut  = outFifoNotEmpty && !strobe.inReset;
    maskIn   = inFifoNotEmpty  && !strobe.inReset;
    maskFull = outFifoFull     && !strobe.inReset;
    errClr   = strobe.errClrWrite ? (regWdata[ERR_W-1:0] & ERR_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOut <= 1'b0;
      prevIn  <= 1'b0;
      outSvc  <= 1'b0;
      inSvc   <= 1'b0;
    end else begin
      prevOut <= maskOut;
      prevIn  <= maskIn;
      if (strobe.inReset) outSvc <= 1'b0;
      else if (prevOut && !maskOut) outSvc <= 1'b1;
      else if (strobe.opWrite && regWdata[OPB_OUT_SVC]) outSvc <= 1'b0;
      if (strobe.inReset) inSvc <= 1'b0;
      else if (maskIn && !prevIn) inSvc <= 1'b1;
      else if (strobe.opWrite && regWdata[OPB_IN_SVC]) inSvc <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlags <= '0;
      errEn    <= '0;
    end else begin
      errFlags <= (errFlags & ~errClr) | (errEvent & ERR_MASK);
      if (strobe.errEnWrite) errEn <= regWdata[ERR_W-1:0] & ERR_MASK;
    end
  end

  assign errIrq = |(errFlags & errEn);

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_STATE)) begin
      regRdata[1:0] = curState;
      regRdata[2]   = coreValid;
    end else if (regAddr == ADDR_W'(ADDR_OPER)) begin
      regRdata[OPB_OUT_NE]   = maskOut;
      regRdata[OPB_IN_NE]    = maskIn;
      regRdata[OPB_OUT_FULL] = maskFull;
      regRdata[OPB_OUT_SVC]  = outSvc;
      regRdata[OPB_IN_SVC]   = inSvc;
    end else if (regAddr == ADDR_W'(ADDR_ERRFLG)) begin
      regRdata[ERR_W-1:0] = errFlags;
    end else if (regAddr == ADDR_W'(ADDR_ERREN)) begin
      regRdata[ERR_W-1:0] = errEn;
    end
  end

  assert_oper_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inReset && regAddr == ADDR_W'(ADDR_OPER))
      |-> (regRdata[OPB_OUT_FULL:OPB_OUT_NE] == 3'b000));

  assert_out_svc_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inReset && $past(!strobe.inReset) && $fell(outFifoNotEmpty)) |=> outSvc);

  assert_svc_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inReset |=> (!outSvc && !inSvc));

  assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((errEvent & ERR_MASK) != '0)
      |=> ((errFlags & $past(errEvent & ERR_MASK)) == $past(errEvent & ERR_MASK)));

endmodule

// File: rtl/serialCoreCtrl.sv
module serialCoreCtrl
  import sccPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              outFifoNotEmpty,
  input  logic              inFifoNotEmpty,
  input  logic              outFifoFull,
  input  logic [6:0]        errEvent,
  output logic [1:0]        coreState,
  output logic              coreValid,
  output logic              fifoFlush,
  output logic              errIrq
);

  coreState_e  curState;
  ctrlStrobe_t strobe;

  sccControl #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWe     (regWe),
    .regAddr   (regAddr),
    .wrCode    (regWdata[1:0]),
    .curState  (curState),
    .coreValid (coreValid),
    .fifoFlush (fifoFlush),
    .strobe    (strobe)
  );

  sccDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .regAddr         (regAddr),
    .regWdata        (regWdata),
    .curState        (curState),
    .coreValid       (coreValid),
    .outFifoNotEmpty (outFifoNotEmpty),
    .inFifoNotEmpty  (inFifoNotEmpty),
    .outFifoFull     (outFifoFull),
    .errEvent        (errEvent),
    .regRdata        (regRdata),
    .errIrq          (errIrq)
  );

  assign coreState = curState;

endmodule

// File: tb/sim_serialCoreCtrl.sv
`timescale 1ns/1ps
module sim_serialCoreCtrl;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [2:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        outFifoNotEmpty, inFifoNotEmpty, outFifoFull;
  logic [6:0]  errEvent;
  logic [1:0]  coreState;
  logic        coreValid, fifoFlush, errIrq;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serialCoreCtrl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .outFifoNotEmpty(outFifoNotEmpty), .inFifoNotEmpty(inFifoNotEmpty),
    .outFifoFull(outFifoFull), .errEvent(errEvent),
    .coreState(coreState), .coreValid(coreValid),
    .fifoFlush(fifoFlush), .errIrq(errIrq)
  );

  // {addr[2:0], data[3:0], idleBefore[3:0], expectedStateReadback[2:0]}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 4'd1, 4'd0, 3'd1},  // R2 RESET->RUN, settled low
    {3'd0, 4'd3, 4'd0, 3'd1},  // R3 write while unsettled ignored
    {3'd0, 4'd3, 4'd5, 3'd3},  // R2 RUN->PAUSE after settle
    {3'd0, 4'd2, 4'd5, 3'd7},  // R4 first write of 2 arms only
    {3'd2, 4'd0, 4'd0, 3'd7},  // R4 other write cancels arm
    {3'd0, 4'd2, 4'd0, 3'd7},  // R4 arm again
    {3'd0, 4'd2, 4'd0, 3'd0},  // R4 second write -> RESET
    {3'd0, 4'd2, 4'd5, 3'd4},  // R4 code 2 outside PAUSE ignored
    {3'd0, 4'd1, 4'd0, 3'd1},  // R2 RESET->RUN
    {3'd1, 4'd1, 4'd0, 3'd0},  // R5 software reset while unsettled
    {3'd0, 4'd3, 4'd5, 3'd3},  // R2 RESET->PAUSE
    {3'd0, 4'd0, 4'd5, 3'd7},  // R4 write 0 in PAUSE ignored
    {3'd0, 4'd1, 4'd0, 3'd1}   // R2 PAUSE->RUN
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #0.5;
    v = regRdata;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nVec++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    outFifoNotEmpty = 1'b0; inFifoNotEmpty = 1'b0; outFifoFull = 1'b0; errEvent = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    rd(3'd0, v); check("R1 state after reset", v, 32'h4);
    rd(3'd2, v); check("R6 oper after reset", v, 32'h0);
    check("R1 coreState port", {30'b0, coreState}, 32'h0);
    check("R1 coreValid port", {31'b0, coreValid}, 32'h1);
    check("R6 fifoFlush idle", {31'b0, fifoFlush}, 32'h0);

    // Table walk of state transitions
    for (int i = 0; i < NV; i++) begin
      repeat (int'(VEC[i][6:3])) @(negedge clk);
      wr(VEC[i][13:11], 32'(VEC[i][10:7]));
      rd(3'd0, v);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), v, 32'(VEC[i][2:0]));
    end

    // R2: exact settle window
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h3);
    repeat (3) @(negedge clk);
    check("R2 settled still low after 4th cycle", {31'b0, coreValid}, 32'h0);
    @(negedge clk);
    check("R2 settled back high", {31'b0, coreValid}, 32'h1);

    // R6/R8: operational mirror and input service in PAUSE
    outFifoNotEmpty = 1'b1; inFifoNotEmpty = 1'b1; outFifoFull = 1'b1;
    @(negedge clk);
    rd(3'd2, v); check("R6 R8 oper mirror and in service", v, 32'h270);
    outFifoNotEmpty = 1'b0; outFifoFull = 1'b0;
    @(negedge clk);
    rd(3'd2, v); check("R7 out service on drain", v, 32'h320);
    repeat (3) @(negedge clk);
    wr(3'd2, 32'h100);
    rd(3'd2, v); check("R7 out service cleared", v, 32'h220);
    repeat (3) @(negedge clk);
    rd(3'd2, v); check("R7 no re-set while low", v, 32'h220);
    wr(3'd2, 32'h200);
    rd(3'd2, v); check("R8 in service cleared", v, 32'h20);

    // R6/R9: flush and flag clearing on entry into RESET
    outFifoNotEmpty = 1'b1;
    @(negedge clk);
    outFifoNotEmpty = 1'b0;
    @(negedge clk);
    rd(3'd2, v); check("R7 out service set again", v, 32'h120);
    wr(3'd0, 32'h2);
    wr(3'd0, 32'h2);
    check("R6 fifoFlush pulse", {31'b0, fifoFlush}, 32'h1);
    @(negedge clk);
    check("R6 fifoFlush one cycle", {31'b0, fifoFlush}, 32'h0);
    rd(3'd2, v); check("R6 R9 oper zero in RESET", v, 32'h0);
    check("R4 coreState RESET", {30'b0, coreState}, 32'h0);

    // R10: error flags and enables
    errEvent = 7'h7F;
    @(negedge clk);
    errEvent = '0;
    rd(3'd3, v); check("R10 flags masked capture", v, 32'h7C);
    check("R10 irq off without enable", {31'b0, errIrq}, 32'h0);
    wr(3'd4, 32'hFF);
    rd(3'd4, v); check("R10 enable masked", v, 32'h7C);
    check("R10 irq on", {31'b0, errIrq}, 32'h1);
    wr(3'd3, 32'h04);
    rd(3'd3, v); check("R10 single clear", v, 32'h78);
    wr(3'd3, 32'h7C);
    rd(3'd3, v); check("R10 all cleared", v, 32'h0);
    check("R10 irq off after clear", {31'b0, errIrq}, 32'h0);

    finishRun();
  end

endmodule